// File: doc/BRIEF.md
# DRAM Clock-Enable Power-Down Controller

This block places each rank of a multi-rank DDR3 memory interface into a clock-enable power-down when the rank has gone quiet, and brings it back when traffic returns. Every rank runs its own sequencer. The sequencer counts idle cycles and picks a power-down flavour from a two-bit mode field. It drops that rank's CKE, and when a request shows up again it raises CKE and times the exit wait. The command scheduler sees the end of that wait on a per-rank command-ready flag, and the data path sees it on a per-rank data-ready flag.

There are three power-down flavours. The first keeps open pages and relies on whatever bank state the rank had at entry. The second precharges the rank first through a request/acknowledge handshake with the scheduler. The third also turns off the memory's DLL, which adds a second, longer wait after the command wait before data may move. The block also controls the output enables for the CKE and chip-select pins. Out of reset every rank is driven. A single configuration write that carries both an enable bit and a population mask can later stop driving the ranks that are not fitted.

Top module: `cke_pd_ctrl`

## Requirements
- R1: After reset every rank has CKE high, CKE and chip-select output enables high, cmd_ready and data_ready high, pre_all_req low and pd_open low.
- R2: With cfg_mode = 0, no rank ever drops CKE, however long it stays idle.
- R3: With cfg_mode in 1..3 and cfg_idle = N, a rank whose req_pending falls and stays low has its CKE (or its pre_all_req, where a precharge comes first) go active in the (N+1)-th clock cycle after the first cycle in which req_pending was sampled low.
- R4: With cfg_mode = 1, entry skips any precharge. If bank_open was high at entry the rank is in active power-down and pd_open reads 1; otherwise it is in precharged power-down and pd_open reads 0.
- R5: With cfg_mode = 2, a rank at the entry point first raises pre_all_req and keeps CKE high. CKE falls, and pre_all_req drops, in the cycle after pre_all_ack is sampled high.
- R6: With cfg_mode = 3 (DLL-off), a rank with bank_open high goes through the R5 precharge handshake first. A rank with bank_open low drops CKE directly. In both cases pd_open reads 0.
- R7: A request that arrives while a rank waits for pre_all_ack cancels the entry. In the next cycle the rank has CKE high, pre_all_req low and cmd_ready high.
- R8: When req_pending is sampled high during power-down, CKE rises in the next cycle and cmd_ready rises cfg_txp cycles after CKE (cfg_txp >= 1). In modes 1 and 2, data_ready rises together with cmd_ready.
- R9: In DLL-off power-down, data_ready rises cfg_txpdll cycles after cmd_ready (cfg_txpdll >= 1, typically 10 to 20).
- R10: data_ready is never high while cmd_ready is low. While a rank's CKE is low, neither flag is high.
- R11: The output enables change only on a cycle with cfg_pop_wr high. That write captures cfg_tri_en and cfg_pop_mask together. After it, an enable of 0 drives all ranks, and an enable of 1 drives exactly the ranks whose mask bit is 1, with CKE and chip-select enables always equal.
- R12: Ranks are independent: one rank entering or leaving power-down has no effect on another rank's CKE or ready flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 off, 1 auto active/precharged, 2 precharge then power-down, 3 DLL-off |
| cfg_idle | input | IDLE_W | Idle cycles required before entry |
| cfg_txp | input | TXP_W | Exit wait before commands |
| cfg_txpdll | input | TXPDLL_W | Extra wait before data after DLL-off exit |
| cfg_pop_wr | input | 1 | Strobe capturing cfg_tri_en and cfg_pop_mask |
| cfg_tri_en | input | 1 | Allow tri-stating of unpopulated ranks |
| cfg_pop_mask | input | NUM_RANKS | 1 = rank populated |
| req_pending | input | NUM_RANKS | Rank has outstanding work |
| bank_open | input | NUM_RANKS | Rank has at least one open bank |
| pre_all_ack | input | NUM_RANKS | Scheduler finished precharge-all |
| cke | output | NUM_RANKS | Clock enable per rank |
| cke_oe | output | NUM_RANKS | Output enable for CKE pins |
| cs_oe | output | NUM_RANKS | Output enable for chip-select pins |
| pre_all_req | output | NUM_RANKS | Request to precharge all banks of rank |
| cmd_ready | output | NUM_RANKS | Commands may be issued to rank |
| data_ready | output | NUM_RANKS | Data transfers to rank allowed |
| pd_open | output | NUM_RANKS | Rank is in power-down with pages retained |

## Verification
The bench builds the block with its default parameters: four ranks, an 8-bit idle count, a 4-bit tXP and a 5-bit tXPDLL. With these values it can sweep idle counts from 0 to 5, tXP from 1 to 6 and tXPDLL from 10 to 20, and compare each measured delay with N+1, tXP+1 and tXP+tXPDLL+1. Four ranks let one rank sleep and wake while a neighbour stays busy. They also make the population-mask patterns small enough to write out in full.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;

  typedef enum logic [2:0] {
    ST_ACT   = 3'd0,
    ST_PRE   = 3'd1,
    ST_PD    = 3'd2,
    ST_XP    = 3'd3,
    ST_XPDLL = 3'd4
  } rank_st_e;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_AUTO = 2'd1;
  localparam logic [1:0] MODE_PRE  = 2'd2;
  localparam logic [1:0] MODE_DLL  = 2'd3;

  // Idle window has elapsed once the counter has reached the programmed limit.
  function automatic logic idle_expired(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  // A wait of lim cycles ends on the cycle where cnt reaches lim-1 (lim 0 acts as 1).
  function automatic logic wait_done(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/cke_pop_ctl.sv
module cke_pop_ctl #(
  parameter int NUM_RANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 tri_en,
  input  logic [NUM_RANKS-1:0] mask,
  output logic [NUM_RANKS-1:0] drive_en
);

  logic                 tri_q;
  logic [NUM_RANKS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tri_q  <= 1'b0;
      mask_q <= '1;
    end else if (wr) begin
      tri_q  <= tri_en;
      mask_q <= mask;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_RANKS; i++) begin
      drive_en[i] = !tri_q || mask_q[i];
    end
  end

  assert_oe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr) |-> $stable(drive_en));

  assert_oe_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr) && !$past(tri_en)) |-> (&drive_en));

endmodule

// File: rtl/cke_rank_fsm.sv
module cke_rank_fsm
  import cke_pd_pkg::*;
#(
  parameter int IDLE_W   = 8,
  parameter int TXP_W    = 4,
  parameter int TXPDLL_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic [IDLE_W-1:0]   cfg_idle,
  input  logic [TXP_W-1:0]    cfg_txp,
  input  logic [TXPDLL_W-1:0] cfg_txpdll,
  input  logic                req,
  input  logic                bank_open,
  input  logic                pre_ack,
  output logic                cke,
  output logic                pre_req,
  output logic                cmd_ready,
  output logic                data_ready,
  output logic                pd_open
);

  localparam int CNT_W = (TXP_W > TXPDLL_W) ? TXP_W : TXPDLL_W;

  rank_st_e          state, nxt;
  logic [IDLE_W-1:0] idle_ctr;
  logic [CNT_W-1:0]  xctr;
  logic              apd_q, dll_q;

  // Named internal events
  logic enter_evt, need_pre, xp_done, dll_done, to_pd;

  assign enter_evt = (state == ST_ACT) && (cfg_mode != MODE_OFF) && !req &&
                     idle_expired(32'(idle_ctr), 32'(cfg_idle));
  assign need_pre  = (cfg_mode == MODE_PRE) || ((cfg_mode == MODE_DLL) && bank_open);
  assign xp_done   = (state == ST_XP) && wait_done(32'(xctr), 32'(cfg_txp));
  assign dll_done  = (state == ST_XPDLL) && wait_done(32'(xctr), 32'(cfg_txpdll));
  assign to_pd     = (nxt == ST_PD) && (state != ST_PD);

  always_comb begin
    nxt = state;
    case (state)
      ST_ACT:   if (enter_evt) nxt = need_pre ? ST_PRE : ST_PD;
      ST_PRE:   if (req) nxt = ST_ACT;
                else if (pre_ack) nxt = ST_PD;
      ST_PD:    if (req) nxt = ST_XP;
      ST_XP:    if (xp_done) nxt = dll_q ? ST_XPDLL : ST_ACT;
      ST_XPDLL: if (dll_done) nxt = ST_ACT;
      default:  nxt = ST_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_ACT;
      idle_ctr <= '0;
      xctr     <= '0;
      apd_q    <= 1'b0;
      dll_q    <= 1'b0;
    end else begin
      state <= nxt;
      if (state != ST_ACT || req) idle_ctr <= '0;
      else if (idle_ctr < cfg_idle) idle_ctr <= idle_ctr + 1'b1;
      if (nxt != state) xctr <= '0;
      else if (state == ST_XP || state == ST_XPDLL) xctr <= xctr + 1'b1;
      if (to_pd) begin
        apd_q <= (state == ST_ACT) && (cfg_mode == MODE_AUTO) && bank_open;
        dll_q <= (cfg_mode == MODE_DLL);
      end
    end
  end

  assign cke        = (state != ST_PD);
  assign pre_req    = (state == ST_PRE);
  assign cmd_ready  = (state == ST_ACT) || (state == ST_XPDLL);
  assign data_ready = (state == ST_ACT);
  assign pd_open    = (state == ST_PD) && apd_q;

  assert_no_entry_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(cfg_mode) != MODE_OFF));

  assert_idle_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> !$past(req));

  assert_apd_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_open) |-> ($past(bank_open) && ($past(cfg_mode) == MODE_AUTO)));

  assert_pre_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke) && $past(pre_req)) |-> $past(pre_ack));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cke) && $past(req)) |-> cke);

  assert_rise_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !cmd_ready);

  assert_data_after_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> cmd_ready);

endmodule

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl #(
  parameter int NUM_RANKS = 4,
  parameter int IDLE_W    = 8,
  parameter int TXP_W     = 4,
  parameter int TXPDLL_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic [IDLE_W-1:0]    cfg_idle,
  input  logic [TXP_W-1:0]     cfg_txp,
  input  logic [TXPDLL_W-1:0]  cfg_txpdll,
  input  logic                 cfg_pop_wr,
  input  logic                 cfg_tri_en,
  input  logic [NUM_RANKS-1:0] cfg_pop_mask,
  input  logic [NUM_RANKS-1:0] req_pending,
  input  logic [NUM_RANKS-1:0] bank_open,
  input  logic [NUM_RANKS-1:0] pre_all_ack,
  output logic [NUM_RANKS-1:0] cke,
  output logic [NUM_RANKS-1:0] cke_oe,
  output logic [NUM_RANKS-1:0] cs_oe,
  output logic [NUM_RANKS-1:0] pre_all_req,
  output logic [NUM_RANKS-1:0] cmd_ready,
  output logic [NUM_RANKS-1:0] data_ready,
  output logic [NUM_RANKS-1:0] pd_open
);

  logic [NUM_RANKS-1:0] drive_en;

  cke_pop_ctl #(.NUM_RANKS(NUM_RANKS)) u_pop (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_pop_wr),
    .tri_en   (cfg_tri_en),
    .mask     (cfg_pop_mask),
    .drive_en (drive_en)
  );

  assign cke_oe = drive_en;
  assign cs_oe  = drive_en;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    cke_rank_fsm #(
      .IDLE_W   (IDLE_W),
      .TXP_W    (TXP_W),
      .TXPDLL_W (TXPDLL_W)
    ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_mode   (cfg_mode),
      .cfg_idle   (cfg_idle),
      .cfg_txp    (cfg_txp),
      .cfg_txpdll (cfg_txpdll),
      .req        (req_pending[r]),
      .bank_open  (bank_open[r]),
      .pre_ack    (pre_all_ack[r]),
      .cke        (cke[r]),
      .pre_req    (pre_all_req[r]),
      .cmd_ready  (cmd_ready[r]),
      .data_ready (data_ready[r]),
      .pd_open    (pd_open[r])
    );
  end

endmodule

// File: tb/cke_pd_ctrl_test.sv
module cke_pd_ctrl_test;

  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [7:0]    cfg_idle = 8'd0;
  logic [3:0]    cfg_txp = 4'd1;
  logic [4:0]    cfg_txpdll = 5'd10;
  logic          cfg_pop_wr = 1'b0;
  logic          cfg_tri_en = 1'b0;
  logic [NR-1:0] cfg_pop_mask = '1;
  logic [NR-1:0] req_pending = '1;
  logic [NR-1:0] bank_open = '0;
  logic [NR-1:0] pre_all_ack = '0;
  logic [NR-1:0] cke, cke_oe, cs_oe, pre_all_req, cmd_ready, data_ready, pd_open;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  cke_pd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_idle(cfg_idle),
    .cfg_txp(cfg_txp), .cfg_txpdll(cfg_txpdll), .cfg_pop_wr(cfg_pop_wr),
    .cfg_tri_en(cfg_tri_en), .cfg_pop_mask(cfg_pop_mask),
    .req_pending(req_pending), .bank_open(bank_open), .pre_all_ack(pre_all_ack),
    .cke(cke), .cke_oe(cke_oe), .cs_oe(cs_oe), .pre_all_req(pre_all_req),
    .cmd_ready(cmd_ready), .data_ready(data_ready), .pd_open(pd_open)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Drop the request of rank r and count cycles until the rank reacts.
  // Returns the cycle count at which cke falls (or pre_all_req rises if want_pre).
  task automatic sleep_rank(input int r, input bit want_pre, output int n);
    @(negedge clk);
    req_pending[r] = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      tick();
      n++;
      if (want_pre ? pre_all_req[r] : !cke[r]) break;
    end
  endtask

  // Raise the request of rank r and record when cke, cmd_ready, data_ready rise.
  task automatic wake_rank(input int r, output int nc, output int nk, output int nd);
    @(negedge clk);
    req_pending[r] = 1'b1;
    nc = -1; nk = -1; nd = -1;
    for (int k = 1; k < 100; k++) begin
      tick();
      if (cke[r] && nc < 0) nc = k;
      if (cmd_ready[r] && nk < 0) nk = k;
      if (data_ready[r] && nd < 0) nd = k;
      if (data_ready[r] && cmd_ready[r] && !cke[r]) chk(0, "R10", 1, 0);
      if (data_ready[r] && !cmd_ready[r]) chk(0, "R10", 1, 0);
      if (nd >= 0) break;
    end
  endtask

  task automatic ack_pre(input int r);
    @(negedge clk);
    pre_all_ack[r] = 1'b1;
    tick();
    chk(cke[r] == 1'b0, "R5 cke after ack", int'(cke[r]), 0);
    chk(pre_all_req[r] == 1'b0, "R5 pre_req after ack", int'(pre_all_req[r]), 0);
    @(negedge clk);
    pre_all_ack[r] = 1'b0;
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, nc, nk, nd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk(cke == 4'hF, "R1 cke", int'(cke), 15);
    chk(cke_oe == 4'hF && cs_oe == 4'hF, "R1 oe", int'(cke_oe), 15);
    chk(cmd_ready == 4'hF && data_ready == 4'hF, "R1 ready", int'(cmd_ready), 15);
    chk(pre_all_req == 4'h0 && pd_open == 4'h0, "R1 pre/pd", int'(pre_all_req), 0);

    // R2: mode 0 never powers down
    @(negedge clk);
    cfg_mode = 2'd0;
    req_pending = '0;
    repeat (40) tick();
    chk(cke == 4'hF, "R2 mode0 cke", int'(cke), 15);
    @(negedge clk);
    req_pending = '1;
    tick();

    // R3/R4/R8: mode 1 sweeps over idle count, tXP and bank state
    @(negedge clk);
    cfg_mode = 2'd1;
    foreach (bank_open[i]) bank_open[i] = 1'b0;
    for (int ii = 0; ii < 3; ii++) begin
      for (int tt = 0; tt < 3; tt++) begin
        int idle_v, txp_v, bo;
        idle_v = (ii == 0) ? 0 : (ii == 1 ? 2 : 5);
        txp_v  = (tt == 0) ? 1 : (tt == 1 ? 3 : 6);
        bo     = (ii + tt) % 2;
        @(negedge clk);
        cfg_idle = 8'(idle_v);
        cfg_txp  = 4'(txp_v);
        bank_open[0] = bo[0];
        sleep_rank(0, 1'b0, n);
        chk(n == idle_v + 1, "R3 entry delay", n, idle_v + 1);
        chk(pd_open[0] == bo[0], "R4 pd_open kind", int'(pd_open[0]), bo);
        chk(pre_all_req[0] == 1'b0, "R4 no precharge", int'(pre_all_req[0]), 0);
        wake_rank(0, nc, nk, nd);
        chk(nc == 1, "R8 cke rise", nc, 1);
        chk(nk == txp_v + 1, "R8 cmd_ready delay", nk, txp_v + 1);
        chk(nd == nk, "R8 data with cmd", nd, nk);
      end
    end
    @(negedge clk);
    bank_open = '0;

    // R12: rank 2 sleeps while rank 1 stays busy
    cfg_idle = 8'd3;
    cfg_txp = 4'd2;
    sleep_rank(2, 1'b0, n);
    chk(n == 4, "R12 rank2 entry", n, 4);
    chk(cke[1] && cmd_ready[1] && data_ready[1], "R12 rank1 unaffected", int'(cke[1]), 1);
    chk(cke[3] && cke[0], "R12 other ranks cke", int'(cke), 11);
    wake_rank(2, nc, nk, nd);
    chk(nk == 3, "R12 rank2 wake", nk, 3);

    // R5: mode 2 precharge handshake
    @(negedge clk);
    cfg_mode = 2'd2;
    cfg_idle = 8'd2;
    cfg_txp  = 4'd4;
    bank_open[1] = 1'b1;
    sleep_rank(1, 1'b1, n);
    chk(n == 3, "R5 pre_req delay", n, 3);
    repeat (3) tick();
    chk(cke[1] == 1'b1 && pre_all_req[1], "R5 cke held until ack", int'(cke[1]), 1);
    ack_pre(1);
    chk(pd_open[1] == 1'b0, "R5 precharged kind", int'(pd_open[1]), 0);
    wake_rank(1, nc, nk, nd);
    chk(nk == 5 && nd == 5, "R8 mode2 exit", nk, 5);

    // R7: request cancels a pending precharge
    sleep_rank(1, 1'b1, n);
    chk(n == 3, "R7 reach precharge", n, 3);
    @(negedge clk);
    req_pending[1] = 1'b1;
    tick();
    chk(cke[1] && !pre_all_req[1] && cmd_ready[1], "R7 abort", int'(pre_all_req[1]), 0);
    @(negedge clk);
    bank_open = '0;

    // R6/R9: DLL-off with and without open banks
    cfg_mode = 2'd3;
    cfg_idle = 8'd1;
    for (int dd = 0; dd < 3; dd++) begin
      for (int tt = 0; tt < 2; tt++) begin
        int dll_v, txp_v;
        dll_v = 10 + 5 * dd;
        txp_v = (tt == 0) ? 2 : 5;
        @(negedge clk);
        cfg_txpdll = 5'(dll_v);
        cfg_txp = 4'(txp_v);
        bank_open[3] = tt[0];
        if (tt == 1) begin
          sleep_rank(3, 1'b1, n);
          chk(n == 2 && cke[3], "R6 precharge first", n, 2);
          ack_pre(3);
        end else begin
          sleep_rank(3, 1'b0, n);
          chk(n == 2 && !pre_all_req[3], "R6 direct entry", n, 2);
        end
        chk(pd_open[3] == 1'b0, "R6 pd_open", int'(pd_open[3]), 0);
        wake_rank(3, nc, nk, nd);
        chk(nk == txp_v + 1, "R8 dll cmd delay", nk, txp_v + 1);
        chk(nd == txp_v + dll_v + 1, "R9 dll data delay", nd, txp_v + dll_v + 1);
      end
    end
    @(negedge clk);
    bank_open = '0;
    cfg_mode = 2'd0;

    // R11: output enables only on write
    cfg_tri_en = 1'b1;
    cfg_pop_mask = 4'b0101;
    repeat (2) tick();
    chk(cke_oe == 4'hF && cs_oe == 4'hF, "R11 no write no change", int'(cke_oe), 15);
    @(negedge clk);
    cfg_pop_wr = 1'b1;
    tick();
    chk(cke_oe == 4'b0101, "R11 cke_oe mask", int'(cke_oe), 5);
    chk(cs_oe == 4'b0101, "R11 cs_oe mask", int'(cs_oe), 5);
    @(negedge clk);
    cfg_pop_wr = 1'b0;
    cfg_pop_mask = 4'b1010;
    repeat (2) tick();
    chk(cke_oe == 4'b0101, "R11 mask held", int'(cke_oe), 5);
    @(negedge clk);
    cfg_tri_en = 1'b0;
    cfg_pop_mask = 4'b0000;
    cfg_pop_wr = 1'b1;
    tick();
    chk(cke_oe == 4'hF && cs_oe == 4'hF, "R11 disable drives all", int'(cke_oe), 15);
    @(negedge clk);
    cfg_pop_wr = 1'b0;
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule